// File: doc/BRIEF.md
# Interrupt Source Controller with Priority Masking

This block is the source half of a two-level interrupt controller. It holds routing and status for `NUM_SRC` interrupt sources that carry global numbers `BASE` to `BASE+NUM_SRC-1`. Each source has a target server, a current priority, a saved priority and a fixed type. The type is either level-sensitive or message (edge) and is chosen per source by `LEVEL_MAP`. The block watches the raw source lines and accepts configuration commands on one port. It also takes reject, end-of-interrupt and resend requests from the presentation stage. Its output is one delivery stream that carries server, global number and priority.

Priority 0xFF is the masked value. A message that fires while its source is masked is held as masked-pending and goes out when the source is unmasked. Disable parks the live priority in the saved field, and enable brings it back. A resend request starts a walk that visits one source per cycle. Reject and end-of-interrupt requests are still accepted during the walk.

The read port shows the server, priority and status nibble of the source selected by `cfg_num_i`. The nibble bits are: bit 0 asserted, bit 1 sent, bit 2 rejected, bit 3 masked-pending. Within one cycle, events on a source are applied in a fixed order: grant, reject, end-of-interrupt, configuration, line, walk visit.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, every source reads priority 0xFF, status 0000 and server 0. `busy_o` and `dlv_valid_o` are low.
- R2: No delivery is ever issued with priority 0xFF.
- R3: A rising edge on a message source line has one of two outcomes. If the source is unmasked, one delivery of {server, BASE+index, priority} follows two clocks later. If the source is masked, no delivery occurs and status bit 3 (masked-pending) is set.
- R4: On a level source, status bit 0 follows the line. When the source is unmasked, asserted and not sent, it is delivered once and bit 1 (sent) is set. While it stays sent, it is not delivered again.
- R5: A reject sets status bit 2 (rejected) and clears bit 1 (sent).
- R6: A resend raises `busy_o` for exactly `NUM_SRC` cycles and visits each source once. A rejected message source has bit 2 cleared and is redelivered if unmasked. A level source is re-evaluated under the R4 rule.
- R7: End-of-interrupt clears bit 1 of a level source. On a message source it changes no status bit.
- R8: Operation code 0 (route) writes the server, the priority and the saved priority. A message source with masked-pending set and a new priority other than 0xFF is then delivered, and its bit 3 is cleared.
- R9: Operation code 1 (disable) copies the priority into the saved priority and writes 0xFF. Operation code 2 (enable) writes the saved priority back into the priority field. Code 3 does nothing.
- R10: A configuration command whose number is outside BASE to BASE+NUM_SRC-1 raises `cfg_err_o` in the same cycle and changes nothing. Out-of-range reject and end-of-interrupt requests are ignored.
- R11: A resend request that arrives during a walk causes one more full walk right after the current one. A source rejected after its visit is therefore still redelivered.
- R12: At most one delivery goes out per cycle. When several sources are pending at once, the lowest index goes first, and every pending source is delivered in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_line_i | input | NUM_SRC | Raw source lines |
| cfg_valid_i | input | 1 | Configuration command strobe |
| cfg_op_i | input | 2 | 0 route, 1 disable, 2 enable, 3 no-op |
| cfg_num_i | input | NUM_W | Global source number for command and read port |
| cfg_server_i | input | SRV_W | Server for route |
| cfg_prio_i | input | 8 | Priority for route |
| cfg_err_o | output | 1 | Command number out of range |
| rd_server_o | output | SRV_W | Server of selected source |
| rd_prio_o | output | 8 | Priority of selected source |
| rd_flags_o | output | 4 | Status nibble of selected source |
| rej_valid_i | input | 1 | Reject request |
| rej_num_i | input | NUM_W | Global number to reject |
| eoi_valid_i | input | 1 | End-of-interrupt request |
| eoi_num_i | input | NUM_W | Global number for end-of-interrupt |
| resend_i | input | 1 | Resend request |
| busy_o | output | 1 | Resend walk in progress |
| dlv_valid_o | output | 1 | Delivery strobe |
| dlv_server_o | output | SRV_W | Delivery target server |
| dlv_num_o | output | NUM_W | Delivery global number |
| dlv_prio_o | output | 8 | Delivery priority |

## Verification
Two overlaps are provoked on purpose. The first is a resend walk running while reject requests and a second resend request arrive. One source is rejected just before its visit in the first walk, and another just after its visit. The judgement is that each source is delivered exactly once and that `busy_o` stays high for two whole walks. The second overlap is three message lines rising in the same cycle, with the order of the resulting deliveries checked against the index order.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    CFG_ROUTE = 2'd0,
    CFG_OFF   = 2'd1,
    CFG_ON    = 2'd2,
    CFG_NOP   = 2'd3
  } cfg_op_e;

  // bit3..bit0 : masked-pending, rejected, sent, asserted
  typedef struct packed {
    logic mpend;
    logic rejected;
    logic sent;
    logic asserted;
  } src_flags_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter bit          IS_LEVEL = 1'b0,
  parameter int unsigned SRV_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              cfg_hit_i,
  input  cfg_op_e           cfg_op_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              rej_hit_i,
  input  logic              eoi_hit_i,
  input  logic              visit_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o,
  output src_flags_t        flags_o
);
  logic [SRV_W-1:0]  server_q, server_n;
  logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
  src_flags_t        flags_q, flags_n;
  logic              fire_q, fire_n, line_q, eval;
  logic              msg_rise;

  assign msg_rise = line_i & ~line_q;

  always_comb begin
    server_n = server_q;
    prio_n   = prio_q;
    saved_n  = saved_q;
    flags_n  = flags_q;
    fire_n   = fire_q & ~gnt_i;
    eval     = 1'b0;

    if (rej_hit_i) begin
      flags_n.rejected = 1'b1;
      flags_n.sent     = 1'b0;
    end
    if (eoi_hit_i && IS_LEVEL) flags_n.sent = 1'b0;

    if (cfg_hit_i) begin
      case (cfg_op_i)
        CFG_ROUTE: begin
          server_n = cfg_server_i;
          prio_n   = cfg_prio_i;
          saved_n  = cfg_prio_i;
        end
        CFG_OFF: begin
          saved_n = prio_q;
          prio_n  = PRIO_MASKED;
        end
        CFG_ON:  prio_n = saved_q;
        default: ;
      endcase
      eval = 1'b1;
    end

    if (IS_LEVEL) begin
      flags_n.asserted = line_i;
      if (line_i != line_q) eval = 1'b1;
      if (visit_i) eval = 1'b1;
      if (eval && prio_n != PRIO_MASKED && flags_n.asserted && !flags_n.sent) begin
        flags_n.sent = 1'b1;
        fire_n       = 1'b1;
      end
    end else begin
      if (eval && flags_n.mpend && prio_n != PRIO_MASKED) begin
        flags_n.mpend = 1'b0;
        fire_n        = 1'b1;
      end
      if (msg_rise) begin
        if (prio_n == PRIO_MASKED) flags_n.mpend = 1'b1;
        else                       fire_n        = 1'b1;
      end
      if (visit_i && flags_n.rejected) begin
        flags_n.rejected = 1'b0;
        if (prio_n != PRIO_MASKED) fire_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      server_q <= '0;
      prio_q   <= PRIO_MASKED;
      saved_q  <= PRIO_MASKED;
      flags_q  <= '0;
      fire_q   <= 1'b0;
      line_q   <= 1'b0;
    end else begin
      server_q <= server_n;
      prio_q   <= prio_n;
      saved_q  <= saved_n;
      flags_q  <= flags_n;
      fire_q   <= fire_n;
      line_q   <= line_i;
    end
  end

  // a masked source holds its request until unmasked
  assign req_o    = fire_q && (prio_q != PRIO_MASKED);
  assign server_o = server_q;
  assign prio_o   = prio_q;
  assign flags_o  = flags_q;

  // R3
  masked_msg_pends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_LEVEL && msg_rise && prio_q == PRIO_MASKED && !cfg_hit_i) |=> flags_q.mpend);
  // R5
  reject_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rej_hit_i && !visit_i && !cfg_hit_i && line_i == line_q) |=> (flags_q.rejected && !flags_q.sent));
  // R7
  level_eoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_LEVEL && eoi_hit_i && !visit_i && !cfg_hit_i && line_i == line_q) |=> !flags_q.sent);
  // R9
  disable_saves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_i && cfg_op_i == CFG_OFF) |=> (prio_q == PRIO_MASKED && saved_q == $past(prio_q)));
  // R9
  enable_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_hit_i && cfg_op_i == CFG_ON) |=> (prio_q == $past(saved_q) && $stable(saved_q)));
endmodule

// File: rtl/irq_src_walker.sv
module irq_src_walker #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] visit_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic             busy_q, again_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      again_q <= 1'b0;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (idx_q == LAST) begin
      idx_q   <= '0;
      again_q <= 1'b0;
      busy_q  <= again_q | start_i;
    end else begin
      idx_q <= idx_q + 1'b1;
      if (start_i) again_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_visit
    assign visit_o[k] = busy_q && (idx_q == IDX_W'(k));
  end

  assign busy_o = busy_q;

  // R6
  walk_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  // R6
  one_visit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(visit_o));
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] gnt_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (req_i[k] && !any_o) begin
        any_o    = 1'b1;
        gnt_o[k] = 1'b1;
        idx_o    = IDX_W'(k);
      end
    end
  end

  // R12
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R12
  grant_when_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|(gnt_o & req_i)));
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int unsigned          NUM_SRC   = 8,
  parameter int unsigned          BASE      = 16,
  parameter int unsigned          NUM_W     = 8,
  parameter int unsigned          SRV_W     = 2,
  parameter logic [NUM_SRC-1:0]   LEVEL_MAP = 8'hF0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_line_i,
  input  logic               cfg_valid_i,
  input  logic [1:0]         cfg_op_i,
  input  logic [NUM_W-1:0]   cfg_num_i,
  input  logic [SRV_W-1:0]   cfg_server_i,
  input  logic [7:0]         cfg_prio_i,
  output logic               cfg_err_o,
  output logic [SRV_W-1:0]   rd_server_o,
  output logic [7:0]         rd_prio_o,
  output logic [3:0]         rd_flags_o,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               resend_i,
  output logic               busy_o,
  output logic               dlv_valid_o,
  output logic [SRV_W-1:0]   dlv_server_o,
  output logic [NUM_W-1:0]   dlv_num_o,
  output logic [7:0]         dlv_prio_o
);
  localparam int unsigned      IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_W-1:0] BASE_L = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] END_L  = NUM_W'(BASE + NUM_SRC);

  function automatic logic in_range(input logic [NUM_W-1:0] n);
    return (n >= BASE_L) && (n < END_L);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
    logic [NUM_W-1:0] d;
    d = n - BASE_L;
    return d[IDX_W-1:0];
  endfunction

  logic             cfg_ok, rej_ok, eoi_ok;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx;
  cfg_op_e          cfg_op;

  assign cfg_ok  = in_range(cfg_num_i);
  assign rej_ok  = in_range(rej_num_i);
  assign eoi_ok  = in_range(eoi_num_i);
  assign cfg_idx = to_idx(cfg_num_i);
  assign rej_idx = to_idx(rej_num_i);
  assign eoi_idx = to_idx(eoi_num_i);
  assign cfg_op  = cfg_op_e'(cfg_op_i);
  assign cfg_err_o = cfg_valid_i && !cfg_ok;

  logic [NUM_SRC-1:0] visit, req, gnt;
  logic               any;
  logic [IDX_W-1:0]   win;
  logic [SRV_W-1:0]   srv_a  [NUM_SRC];
  logic [PRIO_W-1:0]  prio_a [NUM_SRC];
  src_flags_t         flag_a [NUM_SRC];

  irq_src_walker #(.NUM_SRC(NUM_SRC)) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (resend_i),
    .busy_o  (busy_o),
    .visit_o (visit)
  );

  irq_src_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .gnt_o  (gnt),
    .any_o  (any),
    .idx_o  (win)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    irq_src_slot #(.IS_LEVEL(LEVEL_MAP[k]), .SRV_W(SRV_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .line_i       (src_line_i[k]),
      .cfg_hit_i    (cfg_valid_i && cfg_ok && cfg_idx == IDX_W'(k)),
      .cfg_op_i     (cfg_op),
      .cfg_server_i (cfg_server_i),
      .cfg_prio_i   (cfg_prio_i),
      .rej_hit_i    (rej_valid_i && rej_ok && rej_idx == IDX_W'(k)),
      .eoi_hit_i    (eoi_valid_i && eoi_ok && eoi_idx == IDX_W'(k)),
      .visit_i      (visit[k]),
      .gnt_i        (gnt[k]),
      .req_o        (req[k]),
      .server_o     (srv_a[k]),
      .prio_o       (prio_a[k]),
      .flags_o      (flag_a[k])
    );
  end

  always_comb begin
    rd_server_o = '0;
    rd_prio_o   = '0;
    rd_flags_o  = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cfg_ok && cfg_idx == IDX_W'(k)) begin
        rd_server_o = srv_a[k];
        rd_prio_o   = prio_a[k];
        rd_flags_o  = flag_a[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_valid_o  <= 1'b0;
      dlv_server_o <= '0;
      dlv_num_o    <= '0;
      dlv_prio_o   <= '0;
    end else begin
      dlv_valid_o <= any;
      if (any) begin
        dlv_server_o <= srv_a[win];
        dlv_num_o    <= BASE_L + NUM_W'(win);
        dlv_prio_o   <= prio_a[win];
      end
    end
  end

  // R2
  never_masked_dlv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_prio_o != PRIO_MASKED));
  // R10
  dlv_num_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_num_o >= BASE_L && dlv_num_o < END_L));
endmodule

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_line = '0;
  logic       cfg_valid = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [7:0] cfg_num = '0;
  logic [1:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic       cfg_err;
  logic [1:0] rd_server;
  logic [7:0] rd_prio;
  logic [3:0] rd_flags;
  logic       rej_valid = 1'b0;
  logic [7:0] rej_num = '0;
  logic       eoi_valid = 1'b0;
  logic [7:0] eoi_num = '0;
  logic       resend = 1'b0;
  logic       busy_o, dlv_valid_o;
  logic [1:0] dlv_server_o;
  logic [7:0] dlv_num_o, dlv_prio_o;

  int n_chk = 0, n_fail = 0;
  int dcnt [8];
  int dprio [8];
  int dsrv [8];
  int ord [16];
  int ord_n = 0;
  int busy_cyc = 0;
  int midx;

  always #4 clk = ~clk;

  irq_src_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_line_i(src_line),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_num_i(cfg_num),
    .cfg_server_i(cfg_server), .cfg_prio_i(cfg_prio), .cfg_err_o(cfg_err),
    .rd_server_o(rd_server), .rd_prio_o(rd_prio), .rd_flags_o(rd_flags),
    .rej_valid_i(rej_valid), .rej_num_i(rej_num),
    .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num),
    .resend_i(resend), .busy_o(busy_o), .dlv_valid_o(dlv_valid_o),
    .dlv_server_o(dlv_server_o), .dlv_num_o(dlv_num_o), .dlv_prio_o(dlv_prio_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_cyc++;
      if (dlv_valid_o) begin
        chk("R2 delivery priority not masked", int'(dlv_prio_o != 8'hFF), 1);
        if (dlv_num_o < 16 || dlv_num_o > 23) begin
          chk("R3 delivery number in range", int'(dlv_num_o), 16);
        end else begin
          midx = int'(dlv_num_o) - 16;
          dcnt[midx]++;
          dprio[midx] = int'(dlv_prio_o);
          dsrv[midx] = int'(dlv_server_o);
          if (ord_n < 16) ord[ord_n] = midx;
          ord_n++;
        end
      end
    end
  end

  task automatic clr_log();
    for (int k = 0; k < 8; k++) begin
      dcnt[k] = 0; dprio[k] = 0; dsrv[k] = 0;
    end
    ord_n = 0;
    busy_cyc = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int op, input int num, input int srv, input int prio, output int err);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 2'(op); cfg_num = 8'(num);
    cfg_server = 2'(srv); cfg_prio = 8'(prio);
    #1 err = int'(cfg_err);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic rd(input int num, output int flags, output int prio, output int srv);
    cfg_num = 8'(num);
    #1;
    flags = int'(rd_flags); prio = int'(rd_prio); srv = int'(rd_server);
  endtask

  task automatic pulse_line(input int k);
    @(negedge clk); src_line[k] = 1'b1;
    @(negedge clk); src_line[k] = 1'b0;
  endtask

  task automatic do_rej(input int num);
    @(negedge clk); rej_valid = 1'b1; rej_num = 8'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic do_eoi(input int num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = 8'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
    while (busy_o) @(negedge clk);
    settle(3);
  endtask

  task automatic t_reset();
    int f, p, s;
    clr_log();
    settle(4);
    for (int k = 16; k < 24; k++) begin
      rd(k, f, p, s);
      chk("R1 reset priority", p, 255);
      chk("R1 reset flags", f, 0);
      chk("R1 reset server", s, 0);
    end
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 no delivery after reset", ord_n, 0);
  endtask

  task automatic t_msg();
    int f, p, s, e;
    cfg(0, 16, 2, 5, e);
    clr_log();
    pulse_line(0);
    settle(3);
    chk("R3 unmasked message delivered once", dcnt[0], 1);
    chk("R3 delivery server", dsrv[0], 2);
    chk("R3 delivery priority", dprio[0], 5);
    pulse_line(1);
    settle(3);
    chk("R3 masked message not delivered", dcnt[1], 0);
    rd(17, f, p, s);
    chk("R3 masked-pending bit set", f, 4'b1000);
    cfg(0, 17, 1, 3, e);
    settle(3);
    chk("R8 pending delivered on route", dcnt[1], 1);
    chk("R8 delivered with new priority", dprio[1], 3);
    chk("R8 delivered to new server", dsrv[1], 1);
    rd(17, f, p, s);
    chk("R8 masked-pending cleared", f, 0);
    chk("R8 route wrote priority", p, 3);
  endtask

  task automatic t_level();
    int f, p, s, e;
    cfg(0, 20, 3, 7, e);
    clr_log();
    settle(3);
    chk("R4 low level line not delivered", dcnt[4], 0);
    @(negedge clk); src_line[4] = 1'b1;
    settle(3);
    chk("R4 level delivered", dcnt[4], 1);
    chk("R4 level delivery server", dsrv[4], 3);
    rd(20, f, p, s);
    chk("R4 asserted and sent", f, 4'b0011);
    settle(5);
    chk("R4 no repeat while sent", dcnt[4], 1);
    do_rej(20);
    settle(2);
    rd(20, f, p, s);
    chk("R5 level reject sets rejected clears sent", f, 4'b0101);
    chk("R5 reject does not redeliver", dcnt[4], 1);
    do_resend();
    chk("R6 level re-evaluated on resend", dcnt[4], 2);
    rd(20, f, p, s);
    chk("R6 level sent again", f, 4'b0111);
    do_eoi(20);
    settle(2);
    rd(20, f, p, s);
    chk("R7 level eoi clears sent", f, 4'b0101);
    @(negedge clk); src_line[4] = 1'b0;
    settle(2);
    rd(20, f, p, s);
    chk("R4 asserted follows line low", f, 4'b0100);
    chk("R7 eoi alone does not redeliver", dcnt[4], 2);
  endtask

  task automatic t_reject();
    int f, p, s;
    clr_log();
    do_rej(16);
    settle(2);
    rd(16, f, p, s);
    chk("R5 message reject sets rejected", f, 4'b0100);
    do_eoi(16);
    settle(2);
    rd(16, f, p, s);
    chk("R7 message eoi changes nothing", f, 4'b0100);
    chk("R5 no delivery on reject", dcnt[0], 0);
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
    chk("R6 busy after resend", int'(busy_o), 1);
    while (busy_o) @(negedge clk);
    settle(3);
    chk("R6 busy lasts one walk", busy_cyc, 8);
    chk("R6 rejected message redelivered", dcnt[0], 1);
    chk("R6 redelivery priority", dprio[0], 5);
    rd(16, f, p, s);
    chk("R6 rejected cleared", f, 0);
    clr_log();
    do_rej(18);
    do_resend();
    rd(18, f, p, s);
    chk("R6 masked rejected cleared", f, 0);
    chk("R6 masked rejected not delivered", dcnt[2], 0);
  endtask

  task automatic t_disable();
    int f, p, s, e;
    clr_log();
    cfg(1, 16, 0, 0, e);
    rd(16, f, p, s);
    chk("R9 disable writes masked priority", p, 255);
    pulse_line(0);
    settle(3);
    chk("R9 disabled message not delivered", dcnt[0], 0);
    rd(16, f, p, s);
    chk("R9 disabled message pends", f, 4'b1000);
    cfg(3, 16, 0, 9, e);
    rd(16, f, p, s);
    chk("R9 op 3 leaves priority", p, 255);
    cfg(2, 16, 0, 0, e);
    settle(3);
    rd(16, f, p, s);
    chk("R9 enable restores priority", p, 5);
    chk("R8 pending delivered on enable", dcnt[0], 1);
    chk("R9 enable delivery priority", dprio[0], 5);
    chk("R8 pending cleared on enable", f, 0);
  endtask

  task automatic t_range();
    int f, p, s, e;
    clr_log();
    cfg(0, 24, 1, 2, e);
    chk("R10 number above range errors", e, 1);
    cfg(0, 15, 1, 2, e);
    chk("R10 number below range errors", e, 1);
    cfg(0, 23, 1, 2, e);
    chk("R10 last valid number accepted", e, 0);
    cfg(3, 23, 0, 0, e);
    rd(23, f, p, s);
    chk("R10 in-range route applied", p, 2);
    rd(22, f, p, s);
    chk("R10 neighbour untouched", p, 255);
    rd(16, f, p, s);
    chk("R10 low source untouched", p, 5);
    do_rej(24);
    do_rej(15);
    do_eoi(15);
    settle(2);
    for (int k = 16; k < 20; k++) begin
      rd(k, f, p, s);
      chk("R10 out-of-range reject ignored", f, 0);
    end
  endtask

  task automatic t_again();
    int f, p, s, e;
    cfg(0, 19, 0, 9, e);
    clr_log();
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
    @(negedge clk);
    @(negedge clk); rej_valid = 1'b1; rej_num = 8'd19;
    @(negedge clk); rej_num = 8'd16; resend = 1'b1;
    @(negedge clk); rej_valid = 1'b0; resend = 1'b0;
    while (busy_o) @(negedge clk);
    settle(3);
    chk("R11 busy spans two walks", busy_cyc, 16);
    chk("R11 source rejected before visit delivered once", dcnt[3], 1);
    chk("R11 source rejected after visit delivered once", dcnt[0], 1);
    rd(16, f, p, s);
    chk("R11 rejected cleared by second walk", f, 0);
  endtask

  task automatic t_multi();
    int e;
    cfg(0, 18, 1, 4, e);
    clr_log();
    @(negedge clk); src_line[2:0] = 3'b111;
    @(negedge clk); src_line[2:0] = 3'b000;
    settle(5);
    chk("R12 three deliveries", ord_n, 3);
    chk("R12 first is lowest index", ord[0], 0);
    chk("R12 second", ord[1], 1);
    chk("R12 third", ord[2], 2);
    chk("R12 each once src2", dcnt[2], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_msg();
    t_level();
    t_reject();
    t_disable();
    t_range();
    t_again();
    t_multi();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule